// File: doc/BRIEF.md
# I2C Register-Access Target

This block is an I2C target that lives on an open-drain SCL/SDA pair. It gives a bus controller byte-wide access to an internal file of 128 eight-bit registers. SCL and SDA are brought into the system clock domain through flop synchronizers. Edge detection on the synchronized lines finds START, repeated START and STOP, and marks the rising and falling edges of SCL. The block never drives a line high. It only pulls SDA low through an output-enable.

A write transaction sends the device address with R/W = 0. The first byte after it sets an internal register pointer. Every byte after that is stored at the pointer, and the pointer then moves on by one, wrapping from 127 to 0. A read transaction sends the address with R/W = 1. The block then shifts out register contents from the current pointer, advancing after each byte, until the controller answers with NACK. A repeated START between a pointer write and a read lets the controller read from a chosen register without releasing the bus. A parallel read port lets on-chip logic see the register contents.

Top module: `i2c_regfile_target`

## Requirements
- R1: While reset is high and in the first cycle after it, `sda_oe` is 0 and the register pointer is 0. Every register reads back 0 on the host port until it is written.
- R2: After a START, the block takes 8 bits MSB first on SCL rising edges. When bits 7..1 equal `DEV_ADDR`, it pulls SDA low for the whole ninth SCL pulse. Bit 0 is the direction: 0 means write, 1 means read.
- R3: When the address does not match, the block gives no acknowledge. It keeps `sda_oe` at 0 and changes no register until the next START or STOP.
- R4: In a write transaction, the first byte after the address is acknowledged and loads the pointer from its low 7 bits. Bit 7 of that byte is ignored.
- R5: Each later byte of a write transaction is acknowledged and stored at the pointer, and the pointer then increments by 1.
- R6: The pointer wraps from 127 to 0 for writes and for reads alike.
- R7: In a read transaction, the block drives the register at the pointer MSB first, one bit per SCL low phase, and advances the pointer by one per byte. `sda_oe` does not change while SCL is high.
- R8: When the controller answers a read byte with NACK (SDA high in the ninth pulse), the block stops driving SDA until the next START.
- R9: A repeated START restarts address decoding from any state and keeps the pointer value.
- R10: A data byte cut short by a STOP or a START before its eighth bit is complete is not stored, and the pointer does not move.
- R11: `host_rdata` always shows the register selected by `host_addr`. A write through the bus appears there once the byte's eighth bit is complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Sensed level of the SCL line |
| sda_i | input | 1 | Sensed level of the SDA line |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| host_addr | input | 7 | Register index for the parallel read port |
| host_rdata | output | 8 | Contents of the register at `host_addr` |

## Verification
The assertions assume that SCL high and low phases each last well beyond the three-cycle synchronizer latency. They also assume the controller changes SDA only while SCL is low, except for START and STOP, and never issues START or STOP while the target holds SDA low. The bench controller keeps to this. It holds each quarter of an SCL period for ten system clocks and moves SDA only in the middle of the low phase. It releases SDA and answers with NACK before any STOP that follows a read.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_RX_PTR,
        ST_ACK_PTR,
        ST_RX_DATA,
        ST_ACK_DATA,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        logic scl_lvl;
        logic sda_lvl;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic addr_hit(input logic [BYTE_W-1:0] b, input logic [6:0] dev);
        return b[BYTE_W-1:1] == dev;
    endfunction

    function automatic logic is_ack_slot(input tgt_state_e s);
        return (s == ST_ACK_ADDR) || (s == ST_ACK_PTR) || (s == ST_ACK_DATA);
    endfunction

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync
    import i2c_tgt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    localparam int LINES = 2;

    logic [LINES-1:0] line_in;
    logic [LINES-1:0] line_now;
    logic [LINES-1:0] line_prev;

    assign line_in = {scl_i, sda_i};

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain        <= '1;
                line_prev[g] <= 1'b1;
            end else begin
                chain        <= {chain[STAGES-2:0], line_in[g]};
                line_prev[g] <= chain[STAGES-1];
            end
        end
        assign line_now[g] = chain[STAGES-1];
    end

    always_comb begin
        evt.scl_lvl  = line_now[1];
        evt.sda_lvl  = line_now[0];
        evt.scl_rise = line_now[1] & ~line_prev[1];
        evt.scl_fall = ~line_now[1] & line_prev[1];
        evt.start    = line_now[1] & line_prev[1] & line_prev[0] & ~line_now[0];
        evt.stop     = line_now[1] & line_prev[1] & ~line_prev[0] & line_now[0];
    end

endmodule

// File: rtl/i2c_tgt_regs.sv
module i2c_tgt_regs
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [PTR_W-1:0]  raddr_a,
    output logic [BYTE_W-1:0] rdata_a,
    input  logic [PTR_W-1:0]  raddr_b,
    output logic [BYTE_W-1:0] rdata_b
);

    localparam int DEPTH = 1 << PTR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h3C,
    parameter int         PTR_W    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              we,
    output logic [PTR_W-1:0]  waddr,
    output logic [BYTE_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr,
    output tgt_state_e        state
);

    localparam logic [CNT_W-1:0] BYTE_DONE = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] TX_LAST   = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic              dir_rd;
    logic              nack;
    logic              rx_state;
    logic              byte_end;

    assign rx_state = (state == ST_ADDR) || (state == ST_RX_PTR) || (state == ST_RX_DATA);
    assign byte_end = rx_state && evt.scl_fall && (cnt == BYTE_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            ptr    <= '0;
            dir_rd <= 1'b0;
            nack   <= 1'b0;
        end else if (evt.stop) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else if (evt.start) begin
            state <= ST_ADDR;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_ADDR, ST_RX_PTR, ST_RX_DATA: begin
                    if (evt.scl_rise) begin
                        rx_sh <= {rx_sh[BYTE_W-2:0], evt.sda_lvl};
                        cnt   <= cnt + 1'b1;
                    end else if (byte_end) begin
                        cnt <= '0;
                        if (state == ST_ADDR) begin
                            if (addr_hit(rx_sh, DEV_ADDR)) begin
                                dir_rd <= rx_sh[0];
                                state  <= ST_ACK_ADDR;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end else if (state == ST_RX_PTR) begin
                            ptr   <= rx_sh[PTR_W-1:0];
                            state <= ST_ACK_PTR;
                        end else begin
                            ptr   <= ptr + 1'b1;
                            state <= ST_ACK_DATA;
                        end
                    end
                end
                ST_ACK_ADDR: begin
                    if (evt.scl_fall) begin
                        if (dir_rd) begin
                            tx_sh <= rd_data;
                            ptr   <= ptr + 1'b1;
                            state <= ST_TX;
                        end else begin
                            state <= ST_RX_PTR;
                        end
                    end
                end
                ST_ACK_PTR, ST_ACK_DATA: begin
                    if (evt.scl_fall) state <= ST_RX_DATA;
                end
                ST_TX: begin
                    if (evt.scl_fall) begin
                        if (cnt == TX_LAST) begin
                            cnt   <= '0;
                            state <= ST_TX_ACK;
                        end else begin
                            cnt   <= cnt + 1'b1;
                            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (evt.scl_lvl) begin
                        nack <= evt.sda_lvl;
                    end else if (evt.scl_fall) begin
                        if (nack) begin
                            state <= ST_IGNORE;
                        end else begin
                            tx_sh <= rd_data;
                            ptr   <= ptr + 1'b1;
                            state <= ST_TX;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        if (is_ack_slot(state))  sda_oe = 1'b1;
        else if (state == ST_TX) sda_oe = ~tx_sh[BYTE_W-1];
        else                     sda_oe = 1'b0;
    end

    assign we    = byte_end && (state == ST_RX_DATA);
    assign waddr = ptr;
    assign wdata = rx_sh;

endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h3C,
    parameter int         PTR_W       = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [PTR_W-1:0]  host_addr,
    output logic [BYTE_W-1:0] host_rdata
);

    bus_evt_t          evt;
    logic              we;
    logic [PTR_W-1:0]  waddr;
    logic [BYTE_W-1:0] wdata;
    logic [PTR_W-1:0]  ptr;
    logic [BYTE_W-1:0] rd_data;
    tgt_state_e        state;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .evt   (evt)
    );

    i2c_tgt_ctrl #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .rd_data (rd_data),
        .sda_oe  (sda_oe),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .ptr     (ptr),
        .state   (state)
    );

    i2c_tgt_regs #(.PTR_W(PTR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .we      (we),
        .waddr   (waddr),
        .wdata   (wdata),
        .raddr_a (ptr),
        .rdata_a (rd_data),
        .raddr_b (host_addr),
        .rdata_b (host_rdata)
    );

endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker
    import i2c_tgt_pkg::*;
#(
    parameter int PTR_W = 7
) (
    input logic             clk,
    input logic             rst,
    input bus_evt_t         evt,
    input tgt_state_e       state,
    input logic             sda_oe,
    input logic             we,
    input logic [PTR_W-1:0] ptr
);

    // R1: reset leaves SDA released and the pointer at zero
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!sda_oe && ptr == '0));

    // R2: the target only starts pulling SDA right after an SCL falling edge
    a_r2_oe_rises_after_scl_fall: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> $past(evt.scl_fall));

    // R7: SDA drive is held steady across each SCL high phase
    a_r7_stable_while_high: assert property (@(posedge clk) disable iff (rst)
        (evt.scl_lvl && $past(evt.scl_lvl)) |-> $stable(sda_oe));

    // R5: each stored byte advances the pointer by one
    a_r5_ptr_steps_after_write: assert property (@(posedge clk) disable iff (rst)
        we |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    // R9: a START always returns the engine to address decoding
    a_r9_start_restarts: assert property (@(posedge clk) disable iff (rst)
        evt.start |=> (state == ST_ADDR));

    // R10: a STOP always returns the engine to idle
    a_r10_stop_idles: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> (state == ST_IDLE));

    // R10: a store only happens while SCL is low, never on a START or STOP
    a_r10_write_on_scl_low: assert property (@(posedge clk) disable iff (rst)
        we |-> (!evt.scl_lvl && !evt.start && !evt.stop));

endmodule

bind i2c_regfile_target i2c_tgt_checker #(.PTR_W(PTR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .state  (state),
    .sda_oe (sda_oe),
    .we     (we),
    .ptr    (ptr)
);

// File: tb/i2c_regfile_target_bench.sv
module i2c_regfile_target_bench;

    localparam logic [6:0] DEV = 7'h3C;
    localparam int Q = 10;

    typedef struct packed {
        logic [7:0] ptr_byte;
        logic [7:0] data;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{8'h00, 8'hA5},
        '{8'h01, 8'h3C},
        '{8'h7F, 8'h81},
        '{8'h85, 8'h5A},
        '{8'h40, 8'h00},
        '{8'h2B, 8'hFF}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    logic [6:0] host_addr = '0;
    logic [7:0] host_rdata;

    int checks = 0;
    int fails  = 0;
    int oe_seen = 0;
    bit oe_watch = 1'b0;
    logic [7:0] model [128];

    assign sda_line = ~(m_low | sda_oe);

    always #10 clk = ~clk;

    i2c_regfile_target u_i2c_regfile_target (
        .clk        (clk),
        .rst        (rst),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .host_addr  (host_addr),
        .host_rdata (host_rdata)
    );

    always @(posedge clk) if (oe_watch && sda_oe) oe_seen++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic put_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_low = ~b[i]; tick(Q);
            m_scl = 1'b1;  tick(2 * Q);
            m_scl = 1'b0;  tick(Q);
        end
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        put_bits(b, 8);
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        acked = ~sda_line; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] b);
        m_low = 1'b0;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b = {b[6:0], sda_line}; tick(Q);
            m_scl = 1'b0;
        end
        tick(Q);
        m_low = give_ack; tick(Q);
        m_scl = 1'b1; tick(2 * Q);
        m_scl = 1'b0; tick(Q);
        m_low = 1'b0;
    endtask

    task automatic host_chk(input logic [6:0] a, input string req);
        host_addr = a; tick(1);
        chk(host_rdata == model[a], req, "host register", host_rdata, model[a]);
    endtask

    task automatic set_ptr(input logic [7:0] p, input string req);
        bit ak;
        bus_start();
        put_byte({DEV, 1'b0}, ak); chk(ak, "R2", "write address ack", ak, 1);
        put_byte(p, ak);           chk(ak, req, "pointer ack", ak, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit ak;
        logic [7:0] rb;
        logic [6:0] p;
        for (int i = 0; i < 128; i++) model[i] = '0;

        // R1: reset state
        tick(5);
        chk(sda_oe == 1'b0, "R1", "sda_oe during reset", sda_oe, 0);
        rst = 1'b0; tick(2);
        chk(sda_oe == 1'b0, "R1", "sda_oe after reset", sda_oe, 0);
        host_chk(7'h00, "R1");
        host_chk(7'h55, "R1");
        host_chk(7'h7F, "R1");

        // Table walk: single writes (R4, R5, R11), read-back through repeated START (R7, R9)
        for (int v = 0; v < 6; v++) begin
            p = VECS[v].ptr_byte[6:0];
            set_ptr(VECS[v].ptr_byte, "R4");
            put_byte(VECS[v].data, ak); chk(ak, "R5", "data ack", ak, 1);
            bus_stop();
            model[p] = VECS[v].data;
            host_chk(p, "R11");
            set_ptr(VECS[v].ptr_byte, "R4");
            bus_start();
            put_byte({DEV, 1'b1}, ak); chk(ak, "R9", "read address ack after Sr", ak, 1);
            get_byte(1'b0, rb);
            chk(rb == model[p], "R7", "read-back byte", rb, model[p]);
            bus_stop();
        end

        // R6: burst write across the top of the file
        set_ptr(8'h7E, "R4");
        put_byte(8'h11, ak); chk(ak, "R5", "burst ack 0", ak, 1);
        put_byte(8'h22, ak); chk(ak, "R5", "burst ack 1", ak, 1);
        put_byte(8'h33, ak); chk(ak, "R6", "burst ack wrapped", ak, 1);
        bus_stop();
        model[7'h7E] = 8'h11; model[7'h7F] = 8'h22; model[7'h00] = 8'h33;
        host_chk(7'h7E, "R5");
        host_chk(7'h7F, "R5");
        host_chk(7'h00, "R6");

        // R7/R6: burst read with wrap, then R8 release after NACK
        set_ptr(8'h7F, "R4");
        bus_start();
        put_byte({DEV, 1'b1}, ak); chk(ak, "R2", "read address ack", ak, 1);
        get_byte(1'b1, rb); chk(rb == model[7'h7F], "R7", "burst read 0", rb, model[7'h7F]);
        get_byte(1'b1, rb); chk(rb == model[7'h00], "R6", "burst read wrapped", rb, model[7'h00]);
        get_byte(1'b0, rb); chk(rb == model[7'h01], "R7", "burst read 2", rb, model[7'h01]);
        oe_seen = 0; oe_watch = 1'b1;
        put_bits(8'hFF, 8);
        put_bits(8'hFF, 1);
        bus_stop();
        oe_watch = 1'b0;
        chk(oe_seen == 0, "R8", "sda_oe cycles after NACK", oe_seen, 0);

        // R3: wrong address, write and read directions
        oe_seen = 0; oe_watch = 1'b1;
        bus_start();
        put_byte({DEV ^ 7'h01, 1'b0}, ak); chk(!ak, "R3", "no ack on foreign address", ak, 0);
        put_byte(8'h10, ak); chk(!ak, "R3", "no ack on pointer", ak, 0);
        put_byte(8'h99, ak); chk(!ak, "R3", "no ack on data", ak, 0);
        bus_stop();
        bus_start();
        put_byte({DEV ^ 7'h40, 1'b1}, ak); chk(!ak, "R3", "no ack on foreign read", ak, 0);
        put_bits(8'hFF, 8);
        bus_stop();
        oe_watch = 1'b0;
        chk(oe_seen == 0, "R3", "sda_oe cycles while ignored", oe_seen, 0);
        host_chk(7'h10, "R3");

        // R10: partial byte cut by STOP
        set_ptr(8'h30, "R4");
        put_bits(8'hF0, 4);
        bus_stop();
        host_chk(7'h30, "R10");

        // R10/R9: partial byte cut by repeated START, pointer unmoved
        model[7'h31] = 8'hC6;
        set_ptr(8'h31, "R4");
        put_byte(8'hC6, ak); chk(ak, "R5", "data ack", ak, 1);
        bus_stop();
        set_ptr(8'h31, "R4");
        put_bits(8'h0F, 5);
        bus_start();
        put_byte({DEV, 1'b1}, ak); chk(ak, "R9", "ack after Sr mid-byte", ak, 1);
        get_byte(1'b0, rb);
        chk(rb == model[7'h31], "R10", "pointer kept after cut byte", rb, model[7'h31]);
        bus_stop();
        host_chk(7'h31, "R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule